// File: doc/BRIEF.md
# PCI Clock-Run Request Controller

This block controls a shared, open-drain clock-run line for a PCI network device. The host's central clock resource pulls the line high when it wants to stop or slow the bus clock. The device answers by pulling the line low in two cases. A "continue" request keeps the clock running while a packet transfer is still pending. A "start" request asks for a stopped or slowed clock to restart when received data is waiting for DMA, or when a wake packet arrives while wake-on-LAN is armed.

The logic runs on a free-running local clock. Each bus-clock rising edge reaches it as a synchronized single-cycle pulse. The block never drives the line high. It only enables a pull-down. Before it pulls down, it must see the line high at two consecutive bus-clock edges. It then holds the pull-down for exactly two bus-clock edges and lets go. The pin also serves as the power-management event output, so a configuration bit selects which function the pin has. The PME enable bit decides whether the block may pull the line at all.

Top module: `clkrun_ctrl`

## Requirements
- R1: After a synchronous reset, `pin_drv_n` is 1 (no pull-down) and the controller waits idle.
- R2: `fn_sel_clkrun` equals `clkrun_en` (1 = clock-run function, 0 = power-management event function). While `clkrun_en` is 0, `pin_drv_n` stays 1 and any pending request is dropped, so the qualification must start again once the function is selected.
- R3: Continue: with `pme_en`=1, `line_in`=1 and `xfer_pending`=1, the controller counts bus edges (cycles with `bus_edge`=1) that see the line high. Once two have been counted, `pin_drv_n` goes to 0 in the next local cycle.
- R4: Start: `rx_dma_ready`=1, or `wake_hit`=1 together with `wol_mode`=1, leads to the same sequence as R3. A `wake_hit` with `wol_mode`=0 has no effect. No pull-down happens while no bus edges arrive.
- R5: Qualification is abandoned, and its edge count restarts from zero, whenever the line is low or no request is present before the second qualifying edge.
- R6: Once pulling low, the block holds `pin_drv_n`=0 until two bus edges have been counted in that state. It releases in the local cycle after the second edge, whatever the line level and request inputs do.
- R7: With `pme_en`=0, `pin_drv_n` is never 0. Clearing `pme_en` during a pull-down releases the pin in the same cycle, and the controller returns to idle.
- R8: After a release, the block takes one idle cycle and then needs two fresh qualifying edges before it pulls low again. An unserviced interrupt cannot hold the clock, because no interrupt input exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 1 | Sampled clock-run line level (1 = released/high) |
| bus_edge | input | 1 | One-cycle pulse per bus-clock rising edge |
| xfer_pending | input | 1 | A transmit or receive packet is still in progress |
| rx_dma_ready | input | 1 | Received data is waiting for DMA |
| wake_hit | input | 1 | A wake packet has been received |
| wol_mode | input | 1 | Wake-on-LAN is armed |
| clkrun_en | input | 1 | Pin function select: 1 = clock-run, 0 = PME |
| pme_en | input | 1 | PME enable bit; gates every pull-down |
| pin_drv_n | output | 1 | Active-low pull-down enable for the open-drain pad |
| fn_sel_clkrun | output | 1 | Pad function select toward the shared pin mux |

## Verification
The assertions assume that `bus_edge` is a clean single-cycle pulse, that `line_in` already reflects the wired-OR of this block's own pull-down with the host's drive, and that reset is held for several cycles before the first check. The bench feeds `line_in` as the AND of a modelled host level with `pin_drv_n`. It spaces bus edges a few local cycles apart, stops them entirely in some phases, and changes the request and configuration inputs only on falling clock edges.

// File: rtl/clkrun_pkg.sv
package clkrun_pkg;

    typedef enum logic [1:0] {
        CR_IDLE    = 2'd0,
        CR_QUALIFY = 2'd1,
        CR_DRIVE   = 2'd2,
        CR_RELEASE = 2'd3
    } cr_state_e;

    typedef struct packed {
        logic xfer_busy;
        logic rx_dma;
        logic wake;
        logic wol_armed;
    } cr_req_s;

    function automatic int unsigned cr_wider(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cr_cnt_bits(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/cr_cause.sv
module cr_cause
    import clkrun_pkg::*;
(
    input  cr_req_s req,
    input  logic    line_hi,
    input  logic    pme_en,
    output logic    want
);
    logic is_continue;
    logic is_start;

    always_comb begin
        is_continue = req.xfer_busy;
        is_start    = req.rx_dma | (req.wake & req.wol_armed);
        want        = pme_en & line_hi & (is_continue | is_start);
    end

endmodule

// File: rtl/cr_fsm.sv
module cr_fsm
    import clkrun_pkg::*;
#(
    parameter int unsigned QUAL_EDGES = 2,
    parameter int unsigned HOLD_EDGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run_en,
    input  logic      pme_en,
    input  logic      want,
    input  logic      bus_edge,
    output cr_state_e state_o
);
    localparam int unsigned MAXE  = cr_wider(QUAL_EDGES, HOLD_EDGES);
    localparam int unsigned CNT_W = cr_cnt_bits(MAXE);
    localparam logic [CNT_W-1:0] QUAL_LAST = CNT_W'(QUAL_EDGES - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_EDGES - 1);

    cr_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            CR_IDLE: begin
                cnt_d = '0;
                if (want) st_d = CR_QUALIFY;
            end
            CR_QUALIFY: begin
                if (!want) begin
                    st_d  = CR_IDLE;
                    cnt_d = '0;
                end else if (bus_edge) begin
                    if (cnt_q == QUAL_LAST) begin
                        st_d  = CR_DRIVE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            CR_DRIVE: begin
                if (!pme_en) begin
                    st_d  = CR_IDLE;
                    cnt_d = '0;
                end else if (bus_edge) begin
                    if (cnt_q == HOLD_LAST) begin
                        st_d  = CR_RELEASE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            CR_RELEASE: begin
                st_d  = CR_IDLE;
                cnt_d = '0;
            end
            default: begin
                st_d  = CR_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            st_q  <= CR_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign state_o = st_q;

    // R2: PME function selected forces the machine idle
    p_idle_when_off_r2: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (st_q == CR_IDLE));

    // R8: a pull-down is never entered straight from release
    p_no_redrive_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q == CR_RELEASE) |=> (st_q != CR_DRIVE));

endmodule

// File: rtl/clkrun_ctrl.sv
module clkrun_ctrl
    import clkrun_pkg::*;
#(
    parameter int unsigned QUAL_EDGES = 2,
    parameter int unsigned HOLD_EDGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    input  logic bus_edge,
    input  logic xfer_pending,
    input  logic rx_dma_ready,
    input  logic wake_hit,
    input  logic wol_mode,
    input  logic clkrun_en,
    input  logic pme_en,
    output logic pin_drv_n,
    output logic fn_sel_clkrun
);
    cr_req_s   req;
    logic      want;
    cr_state_e state;

    always_comb begin
        req.xfer_busy = xfer_pending;
        req.rx_dma    = rx_dma_ready;
        req.wake      = wake_hit;
        req.wol_armed = wol_mode;
    end

    cr_cause i_cause (
        .req     (req),
        .line_hi (line_in),
        .pme_en  (pme_en),
        .want    (want)
    );

    cr_fsm #(
        .QUAL_EDGES (QUAL_EDGES),
        .HOLD_EDGES (HOLD_EDGES)
    ) i_fsm (
        .clk      (clk),
        .rst      (rst),
        .run_en   (clkrun_en),
        .pme_en   (pme_en),
        .want     (want),
        .bus_edge (bus_edge),
        .state_o  (state)
    );

    // Open-drain: only a pull-down enable ever leaves the block
    assign pin_drv_n     = !((state == CR_DRIVE) && pme_en && clkrun_en);
    assign fn_sel_clkrun = clkrun_en;

    // R7: no pull-down without the PME enable bit
    p_pme_gate_r7: assert property (@(posedge clk) disable iff (rst)
        !pin_drv_n |-> pme_en);

    // R2: no pull-down while the pin serves the PME function
    p_fn_off_r2: assert property (@(posedge clk) disable iff (rst)
        !clkrun_en |-> pin_drv_n);

    // R3: a pull-down begins only after a bus edge that saw the line high
    p_drive_entry_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(pin_drv_n) |-> $past(line_in && bus_edge));

    // R6: with config steady, release follows a bus edge
    p_drive_exit_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(pin_drv_n) && pme_en && clkrun_en) |-> $past(bus_edge));

endmodule

// File: tb/test_clkrun_ctrl.sv
`timescale 1ns/1ps
module test_clkrun_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sys_line = 1'b1;
    logic bus_edge = 1'b0;
    logic xfer_pending = 1'b0, rx_dma_ready = 1'b0, wake_hit = 1'b0, wol_mode = 1'b0;
    logic clkrun_en = 1'b1, pme_en = 1'b1;
    logic pin_drv_n, fn_sel_clkrun, line_in;

    int total = 0;
    int bad = 0;
    int lows = 0;
    bit bus_run = 1'b1;
    int gap = 3;
    int edge_ctr = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    assign line_in = sys_line & pin_drv_n;

    clkrun_ctrl i_clkrun_ctrl (
        .clk(clk), .rst(rst), .line_in(line_in), .bus_edge(bus_edge),
        .xfer_pending(xfer_pending), .rx_dma_ready(rx_dma_ready),
        .wake_hit(wake_hit), .wol_mode(wol_mode), .clkrun_en(clkrun_en),
        .pme_en(pme_en), .pin_drv_n(pin_drv_n), .fn_sel_clkrun(fn_sel_clkrun)
    );

    // Behavioural reference: qualifying-edge tally, hold tally, cooldown flag
    bit m_armed = 0;
    bit m_holding = 0;
    bit m_cool = 0;
    int m_seen = 0;
    int m_held = 0;

    always @(posedge clk) begin
        automatic bit need = pme_en && line_in &&
            (xfer_pending || rx_dma_ready || (wake_hit && wol_mode));
        if (rst || !clkrun_en) begin
            m_armed = 0; m_holding = 0; m_cool = 0; m_seen = 0; m_held = 0;
        end else if (m_cool) begin
            m_cool = 0;
        end else if (m_holding) begin
            if (!pme_en) begin
                m_holding = 0; m_held = 0;
            end else if (bus_edge) begin
                m_held++;
                if (m_held >= 2) begin m_holding = 0; m_held = 0; m_cool = 1; end
            end
        end else if (m_armed) begin
            if (!need) begin
                m_armed = 0; m_seen = 0;
            end else if (bus_edge) begin
                m_seen++;
                if (m_seen >= 2) begin m_armed = 0; m_seen = 0; m_holding = 1; end
            end
        end else if (need) begin
            m_armed = 1; m_seen = 0;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (!rst) begin
            check(cur_req, pin_drv_n, !(m_holding && pme_en && clkrun_en));
            check("R2", fn_sel_clkrun, clkrun_en);
            if (!pin_drv_n) lows++;
        end
    end

    task automatic step();
        @(negedge clk);
        edge_ctr++;
        bus_edge = bus_run && (edge_ctr % gap == 0);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic clear_reqs();
        xfer_pending = 0; rx_dma_ready = 0; wake_hit = 0; wol_mode = 0;
    endtask

    initial begin
        #800000;
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        run(4);
        rst = 0;
        step();
        #1;
        check("R1", pin_drv_n, 1'b1);

        // R2: PME function selected, request pending, no pull-down
        cur_req = "R2"; clkrun_en = 0; xfer_pending = 1; lows = 0;
        run(30);
        check("R2", lows != 0, 1'b0);
        clkrun_en = 1; lows = 0;
        run(30);
        check("R2", lows != 0, 1'b1);

        // R3: continue request, line high, steady edges
        cur_req = "R3"; clear_reqs(); run(6);
        xfer_pending = 1; lows = 0;
        run(40);
        check("R3", lows != 0, 1'b1);

        // R4: start with bus clock stopped, then running slowly
        cur_req = "R4"; clear_reqs(); run(6);
        bus_run = 0; rx_dma_ready = 1; lows = 0;
        run(25);
        check("R4", lows != 0, 1'b0);
        bus_run = 1; gap = 6;
        run(40);
        check("R4", lows != 0, 1'b1);
        rx_dma_ready = 0; gap = 3; run(6);
        wake_hit = 1; wol_mode = 0; lows = 0;
        run(30);
        check("R4", lows != 0, 1'b0);
        wol_mode = 1;
        run(30);
        check("R4", lows != 0, 1'b1);

        // R5: host keeps line low, qualification never completes
        cur_req = "R5"; clear_reqs(); run(6);
        sys_line = 0; xfer_pending = 1; lows = 0;
        run(30);
        check("R5", lows != 0, 1'b0);
        for (int k = 0; k < 8; k++) begin
            sys_line = 1; run(4);
            sys_line = 0; run(2);
        end
        sys_line = 1;

        // R6: request and host level move during the pull-down
        cur_req = "R6"; clear_reqs(); run(6);
        rx_dma_ready = 1;
        while (pin_drv_n) step();
        rx_dma_ready = 0; sys_line = 0;
        run(12);
        sys_line = 1;
        run(6);

        // R7: PME enable cleared, then cleared mid-drive
        cur_req = "R7"; pme_en = 0; xfer_pending = 1; lows = 0;
        run(30);
        check("R7", lows != 0, 1'b0);
        pme_en = 1;
        while (pin_drv_n) step();
        pme_en = 0;
        #1;
        check("R7", pin_drv_n, 1'b1);
        run(10);
        pme_en = 1;

        // R8: back-to-back requests with dense edges
        cur_req = "R8"; gap = 2; xfer_pending = 1;
        run(60);
        gap = 1;
        run(30);
        clear_reqs(); gap = 3;
        run(10);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule